// File: doc/BRIEF.md
# Segment Address Mapper

This block turns logical addresses of a 16-bit-word processor into physical byte addresses. There are two logical windows: a data window and an instruction window. Each window is cut into fixed-size blocks. Each block is steered by a 16-bit map register. The data window has four map registers and the instruction window has two. A map register chooses the target space and a segment number. The physical address is then built by a formula that belongs to that space.

A request also carries a transfer length. The block trims this length so the access ends at or before the end of its logical block. In the test alias window it also ends at or before the 2 KB window edge. Any offset beyond the mapped range gives a fault, and so does any space code with no meaning. A fault comes back with a zero address and a zero length.

The map registers sit at fixed 16-bit addresses on a small configuration port. One shadow address reaches the third data map register.

Top module: `segmap_xlate`

## Requirements
- R1: A data request selects map register (offset / 16384). A data offset of 0x10000 or more faults.
- R2: A data map value with bit 15 clear is decoded by its bits 13:12, with the segment in bits 9:0.
  - Code 00 gives 0x00000000 + seg*16384 + (offset mod 16384).
  - Code 01 gives 0x01000000 + seg*16384 + (offset mod 16384).
- R3: Data map space code 10 gives 0x02000000 + (seg<<16) + regno*16384 + (offset mod 16384). Here regno is the map register index.
- R4: A data map value with bit 15 set selects I/O space. Offset bits 13:12 (q) pick map nibble 3-q, where nibble 3 is bits 15:12. The address is 0x02000000 + nibble*0x10000 + 0xC000 + (offset mod 16384).
- R5: Data map space code 11 with bit 15 clear faults.
- R6: An instruction request selects map register (offset / 16384), with the segment in bits 6:0. An offset of 0x8000 or more faults.
  - Code 00 gives (seg<<17) + (offset mod 16384).
  - Code 01 gives 0x01000000 + regno*16384 + (offset mod 16384).
- R7: Instruction map code 10 faults. Code 11 gives 0x01000000 + t, where t = offset mod 0x800. The length is also clipped to 0x800 - t.
- R8: The returned length is min(requested length, 16384 - (offset mod 16384)).
- R9: Map register addresses are as follows. Instruction maps are at 0xFF00 and 0xFF02. Data maps are at 0xFF08, 0xFF0A, 0xFF0C and 0xFF0E.
  - 0xFF04 reads and writes data map 2.
  - A read returns data and a hit flag one cycle later.
  - An unmapped address returns hit 0.
- R10: After reset, both instruction maps read 0x1000. Data maps 0 to 2 read 0x2000, and data map 3 reads 0x0000.
- R11: A response is valid exactly one cycle after a request. The fault flag is high only for that single response cycle. A faulting response has address 0 and length 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Map register write strobe |
| cfg_rd_en | input | 1 | Map register read strobe |
| cfg_addr | input | 16 | Map register byte address |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Registered read data |
| cfg_hit | output | 1 | Registered flag: the read address decoded to a map register |
| req_valid | input | 1 | Translation request |
| req_insn | input | 1 | 1 = instruction window, 0 = data window |
| req_offset | input | 18 | Logical byte offset |
| req_len | input | 16 | Requested transfer length in bytes |
| rsp_valid | output | 1 | Response valid |
| rsp_phys | output | 32 | Physical byte address |
| rsp_len | output | 16 | Clipped length |
| rsp_fault | output | 1 | Translation fault |

## Verification
Directed requests are used to set each space code and the I/O bit in turn. This separates the formulas for the unified, instruction, on-chip data and I/O spaces. The I/O case uses an offset in the second quarter of a block, which shows that the nibble order runs from the top nibble down. Requests just below and at the window limits separate a valid translation from a range fault. A length near a block end, and near a 2 KB test-window edge, shows which clip applies. Random requests then run against random map contents, including writes through the shadow address, and mix both windows, all spaces and out-of-range offsets.

// File: rtl/segmap_pkg.sv
package segmap_pkg;
  typedef enum logic [1:0] {
    SP_UNI  = 2'b00,
    SP_INSN = 2'b01,
    SP_DATA = 2'b10,
    SP_RSVD = 2'b11
  } space_e;

  localparam logic [31:0] UNI_BASE_D  = 32'h0000_0000;
  localparam logic [31:0] INSN_BASE_D = 32'h0100_0000;
  localparam logic [31:0] DATA_BASE_D = 32'h0200_0000;
  localparam int          MAP_W       = 16;
endpackage

// File: rtl/segmap_regs.sv
module segmap_regs
  import segmap_pkg::*;
#(
  parameter int          N_IMAP    = 2,
  parameter int          N_DMAP    = 4,
  parameter logic [15:0] IMAP_AT   = 16'hFF00,
  parameter logic [15:0] DMAP_AT   = 16'hFF08,
  parameter logic [15:0] ALIAS_AT  = 16'hFF04,
  parameter int          ALIAS_IDX = 2,
  parameter logic [15:0] IMAP_RST  = 16'h1000,
  parameter logic [15:0] DMAP_RST  = 16'h2000,
  parameter logic [15:0] DLAST_RST = 16'h0000
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic                      rd_en,
  input  logic [15:0]               addr,
  input  logic [MAP_W-1:0]          wdata,
  output logic [N_IMAP*MAP_W-1:0]   imaps,
  output logic [N_DMAP*MAP_W-1:0]   dmaps,
  output logic [MAP_W-1:0]          rdata,
  output logic                      hit
);
  logic [N_IMAP-1:0] sel_i;
  logic [N_DMAP-1:0] sel_d;
  logic [MAP_W-1:0]  imap_r [N_IMAP];
  logic [MAP_W-1:0]  dmap_r [N_DMAP];
  logic [MAP_W-1:0]  rd_mux;
  logic              rd_any;

  for (genvar k = 0; k < N_IMAP; k++) begin : g_imap
    assign sel_i[k] = (addr == 16'(32'(IMAP_AT) + 2 * k));
    always_ff @(posedge clk) begin
      if (rst)                   imap_r[k] <= IMAP_RST;
      else if (wr_en && sel_i[k]) imap_r[k] <= wdata;
    end
    assign imaps[k*MAP_W +: MAP_W] = imap_r[k];
  end

  for (genvar k = 0; k < N_DMAP; k++) begin : g_dmap
    localparam logic [15:0] RST_V = (k == N_DMAP - 1) ? DLAST_RST : DMAP_RST;
    if (k == ALIAS_IDX) begin : g_alias
      assign sel_d[k] = (addr == 16'(32'(DMAP_AT) + 2 * k)) || (addr == ALIAS_AT);
    end else begin : g_plain
      assign sel_d[k] = (addr == 16'(32'(DMAP_AT) + 2 * k));
    end
    always_ff @(posedge clk) begin
      if (rst)                   dmap_r[k] <= RST_V;
      else if (wr_en && sel_d[k]) dmap_r[k] <= wdata;
    end
    assign dmaps[k*MAP_W +: MAP_W] = dmap_r[k];
  end

  always_comb begin
    rd_mux = '0;
    for (int k = 0; k < N_IMAP; k++)
      if (sel_i[k]) rd_mux = rd_mux | imap_r[k];
    for (int k = 0; k < N_DMAP; k++)
      if (sel_d[k]) rd_mux = rd_mux | dmap_r[k];
    rd_any = (|sel_i) | (|sel_d);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      hit   <= 1'b0;
    end else if (rd_en) begin
      rdata <= rd_mux;
      hit   <= rd_any;
    end else begin
      hit   <= 1'b0;
    end
  end
endmodule

// File: rtl/segmap_dxlate.sv
module segmap_dxlate
  import segmap_pkg::*;
#(
  parameter int          BLK_BYTES = 16384,
  parameter int          N_MAP     = 4,
  parameter int          OFF_W     = 18,
  parameter int          LEN_W     = 16,
  parameter logic [31:0] UNI_BASE  = UNI_BASE_D,
  parameter logic [31:0] INSN_BASE = INSN_BASE_D,
  parameter logic [31:0] DATA_BASE = DATA_BASE_D,
  parameter logic [31:0] IO_WIN    = 32'h0000_C000,
  parameter logic [31:0] IO_STRIDE = 32'h0001_0000
) (
  input  logic [OFF_W-1:0]       offset,
  input  logic [LEN_W-1:0]       len,
  input  logic [N_MAP*MAP_W-1:0] maps,
  output logic [31:0]            phys,
  output logic [LEN_W-1:0]       len_out,
  output logic                   fault
);
  localparam int          BLK_LG = $clog2(BLK_BYTES);
  localparam logic [31:0] BLK32  = 32'(BLK_BYTES);
  localparam logic [31:0] LIMIT  = 32'(BLK_BYTES * N_MAP);

  logic [31:0]      off32, regno, boff, room, len32, clip, qsh, seg;
  logic [MAP_W-1:0] map;
  logic [3:0]       nib;
  space_e           sp;

  always_comb begin
    off32 = 32'(offset);
    regno = off32 >> BLK_LG;
    boff  = off32 & (BLK32 - 32'd1);
    room  = BLK32 - boff;
    len32 = 32'(len);
    clip  = (len32 < room) ? len32 : room;
    map   = '0;
    for (int k = 0; k < N_MAP; k++)
      if (regno == 32'(k)) map = maps[k*MAP_W +: MAP_W];
    sp  = space_e'(map[13:12]);
    seg = 32'(map[9:0]);
    qsh = boff >> 12;
    case (qsh[1:0])
      2'd0:    nib = map[15:12];
      2'd1:    nib = map[11:8];
      2'd2:    nib = map[7:4];
      default: nib = map[3:0];
    endcase
    phys  = '0;
    fault = 1'b0;
    if (off32 >= LIMIT) begin
      fault = 1'b1;
    end else if (map[15]) begin
      phys = DATA_BASE + IO_STRIDE * 32'(nib) + IO_WIN + boff;
    end else begin
      case (sp)
        SP_UNI:  phys = UNI_BASE + (seg << BLK_LG) + boff;
        SP_INSN: phys = INSN_BASE + (seg << BLK_LG) + boff;
        SP_DATA: phys = DATA_BASE + (seg << 16) + (regno << BLK_LG) + boff;
        default: fault = 1'b1;
      endcase
    end
  end

  assign len_out = fault ? '0 : LEN_W'(clip);
endmodule

// File: rtl/segmap_ixlate.sv
module segmap_ixlate
  import segmap_pkg::*;
#(
  parameter int          BLK_BYTES = 16384,
  parameter int          N_MAP     = 2,
  parameter int          OFF_W     = 18,
  parameter int          LEN_W     = 16,
  parameter int          TEST_WIN  = 2048,
  parameter logic [31:0] UNI_BASE  = UNI_BASE_D,
  parameter logic [31:0] INSN_BASE = INSN_BASE_D,
  parameter int          USEG_SH   = 17
) (
  input  logic [OFF_W-1:0]       offset,
  input  logic [LEN_W-1:0]       len,
  input  logic [N_MAP*MAP_W-1:0] maps,
  output logic [31:0]            phys,
  output logic [LEN_W-1:0]       len_out,
  output logic                   fault
);
  localparam int          BLK_LG = $clog2(BLK_BYTES);
  localparam logic [31:0] BLK32  = 32'(BLK_BYTES);
  localparam logic [31:0] TWIN32 = 32'(TEST_WIN);
  localparam logic [31:0] LIMIT  = 32'(BLK_BYTES * N_MAP);

  logic [31:0]      off32, regno, boff, room, len32, clip, toff, troom, seg;
  logic [MAP_W-1:0] map;
  logic             unused_map_bits;
  space_e           sp;

  always_comb begin
    off32 = 32'(offset);
    regno = off32 >> BLK_LG;
    boff  = off32 & (BLK32 - 32'd1);
    room  = BLK32 - boff;
    len32 = 32'(len);
    clip  = (len32 < room) ? len32 : room;
    map   = '0;
    for (int k = 0; k < N_MAP; k++)
      if (regno == 32'(k)) map = maps[k*MAP_W +: MAP_W];
    sp    = space_e'(map[13:12]);
    seg   = 32'(map[6:0]);
    toff  = boff & (TWIN32 - 32'd1);
    troom = TWIN32 - toff;
    phys  = '0;
    fault = 1'b0;
    if (off32 >= LIMIT) begin
      fault = 1'b1;
    end else begin
      case (sp)
        SP_UNI:  phys = UNI_BASE + (seg << USEG_SH) + boff;
        SP_INSN: phys = INSN_BASE + (regno << BLK_LG) + boff;
        SP_RSVD: begin
          phys = INSN_BASE + toff;
          if (troom < clip) clip = troom;
        end
        default: fault = 1'b1;
      endcase
    end
  end

  assign unused_map_bits = ^{map[15:14], map[11:7]};
  assign len_out = fault ? '0 : LEN_W'(clip);
endmodule

// File: rtl/segmap_xlate.sv
module segmap_xlate
  import segmap_pkg::*;
#(
  parameter int BLK_BYTES = 16384,
  parameter int N_IMAP    = 2,
  parameter int N_DMAP    = 4,
  parameter int OFF_W     = 18,
  parameter int LEN_W     = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr_en,
  input  logic             cfg_rd_en,
  input  logic [15:0]      cfg_addr,
  input  logic [15:0]      cfg_wdata,
  output logic [15:0]      cfg_rdata,
  output logic             cfg_hit,
  input  logic             req_valid,
  input  logic             req_insn,
  input  logic [OFF_W-1:0] req_offset,
  input  logic [LEN_W-1:0] req_len,
  output logic             rsp_valid,
  output logic [31:0]      rsp_phys,
  output logic [LEN_W-1:0] rsp_len,
  output logic             rsp_fault
);
  logic [N_IMAP*MAP_W-1:0] imaps;
  logic [N_DMAP*MAP_W-1:0] dmaps;
  logic [31:0]             d_phys, i_phys;
  logic [LEN_W-1:0]        d_len, i_len;
  logic                    d_fault, i_fault;

  segmap_regs #(.N_IMAP(N_IMAP), .N_DMAP(N_DMAP)) u_regs (
    .clk(clk), .rst(rst), .wr_en(cfg_wr_en), .rd_en(cfg_rd_en),
    .addr(cfg_addr), .wdata(cfg_wdata), .imaps(imaps), .dmaps(dmaps),
    .rdata(cfg_rdata), .hit(cfg_hit)
  );

  segmap_dxlate #(.BLK_BYTES(BLK_BYTES), .N_MAP(N_DMAP), .OFF_W(OFF_W), .LEN_W(LEN_W)) u_dx (
    .offset(req_offset), .len(req_len), .maps(dmaps),
    .phys(d_phys), .len_out(d_len), .fault(d_fault)
  );

  segmap_ixlate #(.BLK_BYTES(BLK_BYTES), .N_MAP(N_IMAP), .OFF_W(OFF_W), .LEN_W(LEN_W)) u_ix (
    .offset(req_offset), .len(req_len), .maps(imaps),
    .phys(i_phys), .len_out(i_len), .fault(i_fault)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_phys  <= '0;
      rsp_len   <= '0;
      rsp_fault <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_phys  <= req_insn ? i_phys  : d_phys;
        rsp_len   <= req_insn ? i_len   : d_len;
        rsp_fault <= req_insn ? i_fault : d_fault;
      end else begin
        rsp_fault <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/segmap_checker.sv
module segmap_checker #(
  parameter int BLK_BYTES = 16384,
  parameter int N_IMAP    = 2,
  parameter int N_DMAP    = 4,
  parameter int OFF_W     = 18,
  parameter int LEN_W     = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_rd_en,
  input logic [15:0]      cfg_addr,
  input logic             cfg_hit,
  input logic             req_valid,
  input logic             req_insn,
  input logic [OFF_W-1:0] req_offset,
  input logic [LEN_W-1:0] req_len,
  input logic             rsp_valid,
  input logic [31:0]      rsp_phys,
  input logic [LEN_W-1:0] rsp_len,
  input logic             rsp_fault
);
  localparam logic [31:0] BLK32 = 32'(BLK_BYTES);
  localparam logic [31:0] DLIM  = 32'(BLK_BYTES * N_DMAP);
  localparam logic [31:0] ILIM  = 32'(BLK_BYTES * N_IMAP);

  p_rsp_follows_req_r11: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!rsp_valid && !rsp_fault));
  p_fault_zeroed_r11: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |-> (rsp_valid && rsp_len == '0 && rsp_phys == '0));
  p_data_limit_r1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_insn && 32'(req_offset) >= DLIM) |=> rsp_fault);
  p_insn_limit_r6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_insn && 32'(req_offset) >= ILIM) |=> rsp_fault);
  p_no_cross_r8: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_fault) |->
      (((32'($past(req_offset)) & (BLK32 - 32'd1)) + 32'(rsp_len)) <= BLK32 &&
       rsp_len <= $past(req_len)));
  p_alias_hit_r9: assert property (@(posedge clk) disable iff (rst)
    (cfg_rd_en && cfg_addr == 16'hFF04) |=> cfg_hit);
endmodule

bind segmap_xlate segmap_checker #(
  .BLK_BYTES(BLK_BYTES), .N_IMAP(N_IMAP), .N_DMAP(N_DMAP), .OFF_W(OFF_W), .LEN_W(LEN_W)
) u_chk (
  .clk(clk), .rst(rst), .cfg_rd_en(cfg_rd_en), .cfg_addr(cfg_addr), .cfg_hit(cfg_hit),
  .req_valid(req_valid), .req_insn(req_insn), .req_offset(req_offset), .req_len(req_len),
  .rsp_valid(rsp_valid), .rsp_phys(rsp_phys), .rsp_len(rsp_len), .rsp_fault(rsp_fault)
);

// File: tb/test_segmap_xlate.sv
`timescale 1ns/1ps
module test_segmap_xlate;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr_en = 1'b0, cfg_rd_en = 1'b0;
  logic [15:0] cfg_addr = '0, cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        cfg_hit;
  logic        req_valid = 1'b0, req_insn = 1'b0;
  logic [17:0] req_offset = '0;
  logic [15:0] req_len = '0;
  logic        rsp_valid, rsp_fault;
  logic [31:0] rsp_phys;
  logic [15:0] rsp_len;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [15:0] imap_m [2];
  logic [15:0] dmap_m [4];

  always #2.5 clk = ~clk;

  segmap_xlate i_segmap_xlate (
    .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_rd_en(cfg_rd_en),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_hit(cfg_hit),
    .req_valid(req_valid), .req_insn(req_insn), .req_offset(req_offset), .req_len(req_len),
    .rsp_valid(rsp_valid), .rsp_phys(rsp_phys), .rsp_len(rsp_len), .rsp_fault(rsp_fault)
  );

  function automatic void model(input bit insn, input logic [31:0] off, input logic [31:0] len,
                                output logic [31:0] ph, output logic [31:0] ln, output bit flt);
    logic [31:0] rn, bo, l, t, q, nib;
    logic [15:0] m;
    rn = off >> 14; bo = off & 32'h3FFF;
    l = (len < 32'h4000 - bo) ? len : 32'h4000 - bo;
    ph = 0; flt = 0;
    if (!insn) begin
      if (off >= 32'h10000) flt = 1;
      else begin
        m = dmap_m[rn[1:0]];
        if (m[15]) begin
          q = (bo >> 12) & 3;
          nib = (32'(m) >> (4 * (3 - q))) & 32'hF;
          ph = 32'h0200_0000 + nib * 32'h10000 + 32'hC000 + bo;
        end else case (m[13:12])
          2'b00: ph = 32'(m[9:0]) * 32'h4000 + bo;
          2'b01: ph = 32'h0100_0000 + 32'(m[9:0]) * 32'h4000 + bo;
          2'b10: ph = 32'h0200_0000 + (32'(m[9:0]) << 16) + rn * 32'h4000 + bo;
          default: flt = 1;
        endcase
      end
    end else begin
      if (off >= 32'h8000) flt = 1;
      else begin
        m = imap_m[rn[0]];
        case (m[13:12])
          2'b00: ph = (32'(m[6:0]) << 17) + bo;
          2'b01: ph = 32'h0100_0000 + rn * 32'h4000 + bo;
          2'b11: begin
            t = bo & 32'h7FF;
            ph = 32'h0100_0000 + t;
            if (32'h800 - t < l) l = 32'h800 - t;
          end
          default: flt = 1;
        endcase
      end
    end
    if (flt) l = 0;
    ln = l;
  endfunction

  task automatic cfg_write(input int idx, input logic [15:0] v);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wdata = v;
    if (idx < 2)       begin cfg_addr = 16'hFF00 + 16'(2 * idx); imap_m[idx] = v; end
    else if (idx < 6)  begin cfg_addr = 16'hFF08 + 16'(2 * (idx - 2)); dmap_m[idx - 2] = v; end
    else               begin cfg_addr = 16'hFF04; dmap_m[2] = v; end
    @(posedge clk); #1;
    cfg_wr_en = 1'b0;
  endtask

  task automatic cfg_read(input logic [15:0] a, input logic [15:0] ev, input bit eh, input string tag);
    @(negedge clk);
    cfg_rd_en = 1'b1; cfg_addr = a;
    @(posedge clk); #1;
    cfg_rd_en = 1'b0;
    checks++;
    if (cfg_hit !== eh || (eh && cfg_rdata !== ev)) begin
      fails++;
      $display("FAIL %s: read %h got data %h hit %b, expected %h hit %b", tag, a, cfg_rdata, cfg_hit, ev, eh);
    end
  endtask

  task automatic xreq(input bit insn, input logic [31:0] off, input logic [31:0] len, input string tag);
    logic [31:0] ep, el;
    bit ef;
    model(insn, off, len, ep, el, ef);
    @(negedge clk);
    req_valid = 1'b1; req_insn = insn; req_offset = off[17:0]; req_len = len[15:0];
    @(posedge clk); #1;
    req_valid = 1'b0;
    checks++;
    if (rsp_valid !== 1'b1 || rsp_fault !== ef || rsp_phys !== ep || rsp_len !== el[15:0]) begin
      fails++;
      $display("FAIL %s: off %h insn %b got v%b f%b phys %h len %h, expected f%b phys %h len %h",
               tag, off, insn, rsp_valid, rsp_fault, rsp_phys, rsp_len, ef, ep, el[15:0]);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    imap_m[0] = 16'h1000; imap_m[1] = 16'h1000;
    dmap_m[0] = 16'h2000; dmap_m[1] = 16'h2000; dmap_m[2] = 16'h2000; dmap_m[3] = 16'h0000;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R11: idle after reset
    checks++;
    if (rsp_valid !== 1'b0 || rsp_fault !== 1'b0) begin
      fails++; $display("FAIL R11: reset got v%b f%b, expected 0 0", rsp_valid, rsp_fault);
    end
    // R10: reset values
    cfg_read(16'hFF00, 16'h1000, 1, "R10");
    cfg_read(16'hFF02, 16'h1000, 1, "R10");
    cfg_read(16'hFF08, 16'h2000, 1, "R10");
    cfg_read(16'hFF0A, 16'h2000, 1, "R10");
    cfg_read(16'hFF0C, 16'h2000, 1, "R10");
    cfg_read(16'hFF0E, 16'h0000, 1, "R10");
    cfg_read(16'hFF06, 16'h0000, 0, "R9 unmapped");
    // R3 with reset maps
    xreq(0, 32'h0000_8004, 32'h10, "R3 reset map");
    // R2
    cfg_write(2, 16'h0005);
    xreq(0, 32'h0000_0010, 32'h8, "R2 unified");
    cfg_write(3, 16'h1003);
    xreq(0, 32'h0000_4020, 32'h8, "R2 insn");
    // R9 alias, R3
    cfg_write(6, 16'h2001);
    cfg_read(16'hFF0C, 16'h2001, 1, "R9 alias write");
    cfg_read(16'hFF04, 16'h2001, 1, "R9 alias read");
    xreq(0, 32'h0000_8100, 32'h20, "R3 onchip data");
    // R4 nibble order
    cfg_write(5, 16'h9A5C);
    xreq(0, 32'h0000_D234, 32'h4, "R4 io quarter1");
    xreq(0, 32'h0000_C010, 32'h4, "R4 io quarter0");
    xreq(0, 32'h0000_F800, 32'h4, "R4 io quarter3");
    // R5
    cfg_write(2, 16'h3000);
    xreq(0, 32'h0000_0100, 32'h4, "R5 reserved");
    // R1 limits
    xreq(0, 32'h0000_FFFE, 32'h4, "R1 last byte");
    xreq(0, 32'h0001_0000, 32'h4, "R1 out of range");
    // R8 clip
    cfg_write(2, 16'h0000);
    xreq(0, 32'h0000_3FF0, 32'h40, "R8 clip");
    xreq(0, 32'h0000_0000, 32'hFFFF, "R8 full block");
    // R6
    cfg_write(0, 16'h0003);
    xreq(1, 32'h0000_0100, 32'h10, "R6 unified");
    cfg_write(1, 16'h1000);
    xreq(1, 32'h0000_4008, 32'h10, "R6 insn");
    xreq(1, 32'h0000_8000, 32'h10, "R6 out of range");
    // R7
    cfg_write(0, 16'h2000);
    xreq(1, 32'h0000_0100, 32'h10, "R7 code10 fault");
    cfg_write(0, 16'h3000);
    xreq(1, 32'h0000_0FF0, 32'h40, "R7 test clip");
    xreq(1, 32'h0000_1804, 32'h8, "R7 test alias");
    // random mix
    for (int i = 0; i < 600; i++) begin
      if (($urandom % 4) == 0) begin
        cfg_write(int'($urandom % 7), 16'($urandom));
      end else begin
        xreq(1'($urandom % 2), $urandom % 32'h12000, $urandom % 32'h5000, "R2 random");
      end
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule